// File: doc/BRIEF.md
# Streaming radix-2 FFT/IFFT pipeline

This block transforms a continuous stream of complex fixed-point samples in frames of N points, with N = 64 by default. Each clock it accepts one sample (I and Q) with a valid flag. A frame mark flags the first sample of each frame. A mode bit is taken with that first sample and selects the forward or the inverse transform for the whole frame. It returns one transformed complex value per clock, in natural bin order, after a fixed latency. Frames may follow each other with no idle cycles in between.

The datapath is a chain of log2(N) radix-2 decimation-in-time butterfly stages. At each stage the stream is split into two paths. One path is delayed so that the upper and lower operands of a butterfly arrive on the same clock. The lower operand is multiplied by a twiddle factor taken from an internal table. A second delay line puts the difference results back into the single output stream. Each butterfly and each multiplier therefore does useful work on half of the cycles.

Every stage halves its results, rounding to nearest with ties to even. This gives an overall scale of 1/N in both directions. The inverse transform uses the same hardware with the twiddles conjugated. The stages leave the bins in bit-reversed order, so a two-bank buffer at the output writes each result at the bit-reversed address and reads the addresses out in order.

Top module: `fft_stream_r2`

## Requirements
- R1: In forward mode (mode bit 0), the k-th output cycle of a frame carries bin k of (1/N)·Σ x[n]·e^(−j2πnk/N), with I on out_re and Q on out_im as two's complement. Each part is within ±2 LSB of the exact value, for inputs whose complex magnitude stays below 2^(DW−1).
- R2: With the mode bit at 1 on the frame's first sample, the frame's k-th output is (1/N)·Σ X[n]·e^(+j2πnk/N), with the same ±2 LSB accuracy as R1. The mode applies to that frame only.
- R3: out_valid first goes high on the clock edge that comes 2N + log2(N) edges after the edge that captures sample 0 of a frame. That is 134 edges for N = 64.
- R4: A frame is N consecutive valid input samples, the first one marked by in_sof. Each frame produces exactly N consecutive out_valid cycles and no extra output cycles.
- R5: Frames that arrive back to back with no idle cycle come out back to back. Each of them meets R3 with respect to its own first sample, and each keeps its own mode.
- R6: After reset, out_valid is low and stays low until a frame has been supplied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample present this cycle |
| in_sof | input | 1 | Marks sample 0 of a frame |
| in_inv | input | 1 | Transform direction, sampled with in_sof: 0 forward, 1 inverse |
| in_re | input | DW | Input real part, signed |
| in_im | input | DW | Input imaginary part, signed |
| out_valid | output | 1 | Output bin present this cycle |
| out_re | output | DW | Output real part, signed |
| out_im | output | DW | Output imaginary part, signed |

## Verification
The bench builds the block with N = 64, DW = 16 and TW = 16. This gives a full six-stage pipeline, with spans from 32 samples down to one, and a 32-entry twiddle table whose quantization and per-stage rounding are measured against an exact transform computed in real arithmetic. The input frames include an impulse, a constant, a single tone and seeded random data. Three of the frames run back to back and change direction between them. This drives both output banks through successive swaps and makes the per-frame mode tag travel alongside the data through every stage.

// File: rtl/fft_stream_pkg.sv
package fft_stream_pkg;

   // Quantize a real value to a signed integer with frac fractional bits.
   function automatic int tw_q(real v, int frac);
      return int'(v * (2.0 ** frac));
   endfunction

   // Reverse the lowest w bits of v.
   function automatic int rev_bits(int v, int w);
      int r;
      r = 0;
      for (int i = 0; i < w; i++) begin
         if (((v >> i) & 1) != 0) r = r | (1 << (w - 1 - i));
      end
      return r;
   endfunction

endpackage

// File: rtl/fft_twiddle_rom.sv
module fft_twiddle_rom #(
   parameter int N  = 64,
   parameter int TW = 16
) (
   input  logic [$clog2(N)-2:0] idx,
   output logic signed [TW-1:0] w_cos,
   output logic signed [TW-1:0] w_sin
);
   import fft_stream_pkg::*;

   localparam int  NT = N / 2;
   localparam int  TF = TW - 2;
   localparam real PI = 3.14159265358979323846;

   logic signed [TW-1:0] rom_c [NT];
   logic signed [TW-1:0] rom_s [NT];

   // The table holds cos and sin of 2*pi*e/N for the first half turn.
   for (genvar e = 0; e < NT; e++) begin : g_ent
      localparam real ANG = 2.0 * PI * real'(e) / real'(N);
      assign rom_c[e] = TW'(tw_q($cos(ANG), TF));
      assign rom_s[e] = TW'(tw_q($sin(ANG), TF));
   end

   assign w_cos = rom_c[idx];
   assign w_sin = rom_s[idx];
endmodule

// File: rtl/fft_dc_stage.sv
module fft_dc_stage #(
   parameter int N  = 64,
   parameter int DW = 16,
   parameter int TW = 16,
   parameter int S  = 0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_vld,
   input  logic                     in_inv,
   input  logic [$clog2(N)-1:0]     in_pos,
   input  logic signed [DW-1:0]     in_re,
   input  logic signed [DW-1:0]     in_im,
   output logic                     out_vld,
   output logic                     out_inv,
   output logic [$clog2(N)-1:0]     out_pos,
   output logic signed [DW-1:0]     out_re,
   output logic signed [DW-1:0]     out_im
);
   import fft_stream_pkg::*;

   localparam int L  = $clog2(N);
   localparam int H  = N >> (S + 1);
   localparam int IW = L - 1;
   localparam int TF = TW - 2;
   localparam int PW = DW + TW + 1;
   localparam int BW = DW + 3;
   localparam logic signed [PW-1:0] RND  = PW'(1) <<< (TF - 1);
   localparam logic signed [BW-1:0] MAXV = BW'((1 << (DW - 1)) - 1);
   localparam logic signed [BW-1:0] MINV = -MAXV;

   // Upper-operand delay line: H samples with their tags.
   logic signed [DW-1:0] d1_re [H];
   logic signed [DW-1:0] d1_im [H];
   logic                 d1_vld [H];
   logic                 d1_inv [H];
   logic [L-1:0]         d1_pos [H];
   // Difference-result delay line: H samples.
   logic signed [DW-1:0] d2_re [H];
   logic signed [DW-1:0] d2_im [H];

   logic signed [DW-1:0] a_re, a_im;
   logic                 a_vld, a_inv, top_sel;
   logic [L-1:0]         a_pos;
   logic [IW-1:0]        tw_idx;
   logic signed [TW-1:0] w_cos, w_sin;
   logic signed [PW-1:0] br, bi, wc, wi, m_re, m_im;
   logic signed [BW-1:0] p_re, p_im, ae_re, ae_im;
   logic signed [DW-1:0] sum_re, sum_im, dif_re, dif_im;

   assign a_re  = d1_re[H-1];
   assign a_im  = d1_im[H-1];
   assign a_vld = d1_vld[H-1];
   assign a_inv = d1_inv[H-1];
   assign a_pos = d1_pos[H-1];
   // The leaving element is an upper one when its span bit is clear.
   assign top_sel = ~a_pos[L-1-S];

   // Halve with round-half-to-even, then clamp to DW bits.
   function automatic logic signed [DW-1:0] halve_sat(logic signed [BW-1:0] v);
      logic signed [BW-1:0] sh, q;
      sh = v >>> 1;
      q  = sh + {{(BW-1){1'b0}}, v[0] & v[1]};
      if (q > MAXV)      q = MAXV;
      else if (q < MINV) q = MINV;
      return DW'(q);
   endfunction

   always_comb begin
      int g, r;
      g = int'(a_pos) >> (L - S);
      r = rev_bits(g, S);
      tw_idx = IW'(r * H);
   end

   fft_twiddle_rom #(.N(N), .TW(TW)) u_rom (
      .idx   (tw_idx),
      .w_cos (w_cos),
      .w_sin (w_sin)
   );

   always_comb begin
      br = PW'(in_re);
      bi = PW'(in_im);
      wc = PW'(w_cos);
      wi = a_inv ? PW'(w_sin) : -PW'(w_sin);
      m_re = br * wc - bi * wi;
      m_im = br * wi + bi * wc;
      p_re = BW'((m_re + RND) >>> TF);
      p_im = BW'((m_im + RND) >>> TF);
      ae_re = BW'(a_re);
      ae_im = BW'(a_im);
      sum_re = halve_sat(ae_re + p_re);
      sum_im = halve_sat(ae_im + p_im);
      dif_re = halve_sat(ae_re - p_re);
      dif_im = halve_sat(ae_im - p_im);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < H; i++) d1_vld[i] <= 1'b0;
         out_vld <= 1'b0;
      end else begin
         for (int i = H - 1; i > 0; i--) d1_vld[i] <= d1_vld[i-1];
         d1_vld[0] <= in_vld;
         out_vld   <= a_vld;
      end
   end

   always_ff @(posedge clk) begin
      for (int i = H - 1; i > 0; i--) begin
         d1_re[i]  <= d1_re[i-1];
         d1_im[i]  <= d1_im[i-1];
         d1_inv[i] <= d1_inv[i-1];
         d1_pos[i] <= d1_pos[i-1];
         d2_re[i]  <= d2_re[i-1];
         d2_im[i]  <= d2_im[i-1];
      end
      d1_re[0]  <= in_re;
      d1_im[0]  <= in_im;
      d1_inv[0] <= in_inv;
      d1_pos[0] <= in_pos;
      d2_re[0]  <= dif_re;
      d2_im[0]  <= dif_im;
      out_re    <= top_sel ? sum_re : d2_re[H-1];
      out_im    <= top_sel ? sum_im : d2_im[H-1];
      out_inv   <= a_inv;
      out_pos   <= a_pos;
   end

   // R1: the lower operand sits exactly one span after the upper one.
   assert_pair_span_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (a_vld && in_vld && top_sel) |-> (in_pos == L'(a_pos + H)));

   // R2: both operands of a butterfly belong to a frame of the same mode.
   assert_mode_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (a_vld && in_vld && top_sel) |-> (a_inv == in_inv));

   // R4: consecutive valid outputs of a stage carry consecutive indices.
   assert_index_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |=> (!out_vld || (out_pos == L'($past(out_pos) + 1'b1))));
endmodule

// File: rtl/fft_reorder.sv
module fft_reorder #(
   parameter int N  = 64,
   parameter int DW = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_vld,
   input  logic                     in_inv,
   input  logic [$clog2(N)-1:0]     in_pos,
   input  logic signed [DW-1:0]     in_re,
   input  logic signed [DW-1:0]     in_im,
   output logic                     out_vld,
   output logic signed [DW-1:0]     out_re,
   output logic signed [DW-1:0]     out_im
);
   import fft_stream_pkg::*;

   localparam int L = $clog2(N);

   logic signed [DW-1:0] mem_re [2][N];
   logic signed [DW-1:0] mem_im [2][N];
   logic                 wbank, rbank, rd_act, done;
   logic [L-1:0]         rd, wa;

   assign wa   = L'(rev_bits(int'(in_pos), L));
   assign done = in_vld && (in_pos == L'(N - 1));

   always_ff @(posedge clk) begin
      if (in_vld) begin
         mem_re[wbank][wa] <= in_re;
         mem_im[wbank][wa] <= in_im;
      end
      out_re <= mem_re[rbank][rd];
      out_im <= mem_im[rbank][rd];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wbank   <= 1'b0;
         rbank   <= 1'b0;
         rd_act  <= 1'b0;
         rd      <= '0;
         out_vld <= 1'b0;
      end else begin
         out_vld <= rd_act;
         if (done) begin
            wbank  <= ~wbank;
            rbank  <= wbank;
            rd_act <= 1'b1;
            rd     <= '0;
         end else if (rd_act) begin
            rd <= rd + 1'b1;
            if (rd == L'(N - 1)) rd_act <= 1'b0;
         end
      end
   end

   // R5: a frame being written never shares a bank with the one being read.
   assert_bank_split_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && rd_act) |-> (wbank != rbank));

   // R5: a new frame completes only as the previous read-out finishes.
   assert_no_overrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rd_act) |-> (rd == L'(N - 1)));

   // R2: the mode tag stays constant across the elements of one frame.
   assert_mode_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && $past(in_vld) && (in_pos != '0)) |-> (in_inv == $past(in_inv)));
endmodule

// File: rtl/fft_stream_r2.sv
module fft_stream_r2 #(
   parameter int N  = 64,
   parameter int DW = 16,
   parameter int TW = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic                 in_sof,
   input  logic                 in_inv,
   input  logic signed [DW-1:0] in_re,
   input  logic signed [DW-1:0] in_im,
   output logic                 out_valid,
   output logic signed [DW-1:0] out_re,
   output logic signed [DW-1:0] out_im
);
   localparam int L = $clog2(N);

   if ((1 << L) != N || N < 4) begin : g_bad_len
      $error("fft_stream_r2: N must be a power of two of at least 4");
   end
   if (TW < 4 || DW < 4) begin : g_bad_width
      $error("fft_stream_r2: DW and TW must be at least 4");
   end

   logic [L-1:0]         cnt, pos_now, x_pos;
   logic                 inv_hold, inv_now, x_vld, x_inv;
   logic signed [DW-1:0] x_re, x_im;

   assign pos_now = in_sof ? '0 : cnt;
   assign inv_now = in_sof ? in_inv : inv_hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         inv_hold <= 1'b0;
         x_vld    <= 1'b0;
      end else begin
         x_vld <= in_valid;
         if (in_valid) begin
            cnt      <= pos_now + 1'b1;
            inv_hold <= inv_now;
         end
      end
   end

   always_ff @(posedge clk) begin
      x_re  <= in_re;
      x_im  <= in_im;
      x_pos <= pos_now;
      x_inv <= inv_now;
   end

   logic                 s_vld [L];
   logic                 s_inv [L];
   logic [L-1:0]         s_pos [L];
   logic signed [DW-1:0] s_re  [L];
   logic signed [DW-1:0] s_im  [L];

   for (genvar S = 0; S < L; S++) begin : g_stage
      logic                 i_vld, i_inv;
      logic [L-1:0]         i_pos;
      logic signed [DW-1:0] i_re, i_im;
      if (S == 0) begin : g_first
         assign i_vld = x_vld;
         assign i_inv = x_inv;
         assign i_pos = x_pos;
         assign i_re  = x_re;
         assign i_im  = x_im;
      end else begin : g_next
         assign i_vld = s_vld[S-1];
         assign i_inv = s_inv[S-1];
         assign i_pos = s_pos[S-1];
         assign i_re  = s_re[S-1];
         assign i_im  = s_im[S-1];
      end
      fft_dc_stage #(.N(N), .DW(DW), .TW(TW), .S(S)) u_stage (
         .clk     (clk),
         .rst_n   (rst_n),
         .in_vld  (i_vld),
         .in_inv  (i_inv),
         .in_pos  (i_pos),
         .in_re   (i_re),
         .in_im   (i_im),
         .out_vld (s_vld[S]),
         .out_inv (s_inv[S]),
         .out_pos (s_pos[S]),
         .out_re  (s_re[S]),
         .out_im  (s_im[S])
      );
   end

   fft_reorder #(.N(N), .DW(DW)) u_reorder (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_vld  (s_vld[L-1]),
      .in_inv  (s_inv[L-1]),
      .in_pos  (s_pos[L-1]),
      .in_re   (s_re[L-1]),
      .in_im   (s_im[L-1]),
      .out_vld (out_valid),
      .out_re  (out_re),
      .out_im  (out_im)
   );

   // R4: a frame mark only arrives once the previous frame is complete.
   assert_sof_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sof) |-> (cnt == '0));
endmodule

// File: tb/sim_fft_stream_r2.sv
module sim_fft_stream_r2;
   localparam int N   = 64;
   localparam int L   = 6;
   localparam int LAT = 2 * N + L;
   localparam int NF  = 7;
   localparam real PI = 3.14159265358979323846;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, in_sof = 1'b0, in_inv = 1'b0;
   logic signed [15:0] in_re = '0, in_im = '0;
   logic out_valid;
   logic signed [15:0] out_re, out_im;

   always #4 clk = ~clk;

   fft_stream_r2 #(.N(N), .DW(16), .TW(16)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
      .in_inv(in_inv), .in_re(in_re), .in_im(in_im),
      .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int fin_re [NF][N];
   int fin_im [NF][N];
   bit finv [NF];
   int tcap [NF];
   int got_re [NF][N];
   int got_im [NF][N];
   int tfirst [NF];
   int tlast [NF];
   int nout = 0;
   bit started = 0;
   bit early = 0;
   int errors = 0;
   int checks = 0;

   always @(negedge clk) begin
      if (out_valid) begin
         int f, k;
         if (!started) early = 1;
         f = nout / N;
         k = nout % N;
         if (f < NF) begin
            got_re[f][k] = int'(out_re);
            got_im[f][k] = int'(out_im);
            if (k == 0) tfirst[f] = cyc;
            if (k == N - 1) tlast[f] = cyc;
         end
         nout++;
      end
   end

   task automatic check(bit ok, string req, string what, string act, string exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %s expected %s", req, what, act, exp);
      end
   endtask

   task automatic send(int f);
      for (int n = 0; n < N; n++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_sof   = (n == 0);
         in_inv   = finv[f];
         in_re    = 16'(fin_re[f][n]);
         in_im    = 16'(fin_im[f][n]);
         if (n == 0) begin
            tcap[f] = cyc + 1;
            started = 1;
         end
      end
   endtask

   task automatic idle(int c);
      for (int i = 0; i < c; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_sof   = 1'b0;
         in_re    = '0;
         in_im    = '0;
      end
   endtask

   // Exact scaled transform, worst deviation over both parts of all bins.
   task automatic check_frame(int f);
      real worst, er, ei, th, sg;
      int wk;
      string req;
      worst = 0.0;
      wk = 0;
      er = 0.0;
      ei = 0.0;
      sg = finv[f] ? 1.0 : -1.0;
      req = finv[f] ? "R2" : "R1";
      for (int k = 0; k < N; k++) begin
         real xr, xi, dr, di;
         xr = 0.0;
         xi = 0.0;
         for (int n = 0; n < N; n++) begin
            th = 2.0 * PI * real'((n * k) % N) / real'(N);
            xr += real'(fin_re[f][n]) * $cos(th) - sg * real'(fin_im[f][n]) * $sin(th);
            xi += real'(fin_im[f][n]) * $cos(th) + sg * real'(fin_re[f][n]) * $sin(th);
         end
         xr = xr / real'(N);
         xi = xi / real'(N);
         dr = real'(got_re[f][k]) - xr;
         di = real'(got_im[f][k]) - xi;
         if (dr < 0.0) dr = -dr;
         if (di < 0.0) di = -di;
         if (dr > worst || di > worst) begin
            worst = (dr > di) ? dr : di;
            wk = k;
            er = xr;
            ei = xi;
         end
      end
      check(worst <= 2.0, req, $sformatf("frame %0d bin %0d value", f, wk),
            $sformatf("(%0d,%0d)", got_re[f][wk], got_im[f][wk]),
            $sformatf("(%0.2f,%0.2f) within 2 LSB", er, ei));
   endtask

   initial begin
      void'($urandom(32'd2718));
      for (int f = 0; f < NF; f++) begin
         for (int n = 0; n < N; n++) begin
            fin_re[f][n] = 0;
            fin_im[f][n] = 0;
         end
         finv[f] = 1'b0;
      end
      fin_re[0][0] = 16000;                       // impulse, forward
      for (int n = 0; n < N; n++) fin_re[1][n] = 6400;   // constant, forward
      for (int n = 0; n < N; n++) begin           // tone in bin 5, forward
         fin_re[2][n] = int'(12000.0 * $cos(2.0 * PI * 5.0 * real'(n) / real'(N)));
         fin_im[2][n] = int'(12000.0 * $sin(2.0 * PI * 5.0 * real'(n) / real'(N)));
      end
      for (int n = 0; n < N; n++) begin           // random frames
         fin_re[3][n] = int'($urandom_range(12000)) - 6000;
         fin_im[3][n] = int'($urandom_range(12000)) - 6000;
         fin_re[4][n] = int'($urandom_range(12000)) - 6000;
         fin_im[4][n] = int'($urandom_range(12000)) - 6000;
         fin_re[6][n] = int'($urandom_range(12000)) - 6000;
         fin_im[6][n] = int'($urandom_range(12000)) - 6000;
      end
      fin_re[5][3] = 16000;                       // single bin, inverse
      finv[5] = 1'b1;
      finv[6] = 1'b1;

      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      // R6: no output after reset while nothing has been sent
      check(!early && !out_valid, "R6", "out_valid after reset",
            $sformatf("%0d", early | out_valid), "0");

      for (int f = 0; f < 4; f++) begin
         send(f);
         idle(7);
      end
      // R5: three frames back to back, direction switching in between
      send(4);
      send(5);
      send(6);
      idle(1);

      while (nout < NF * N && cyc < 5000) @(negedge clk);
      idle(200);

      // R4: exactly N outputs per frame, nothing extra
      check(nout == NF * N, "R4", "total output cycles",
            $sformatf("%0d", nout), $sformatf("%0d", NF * N));

      if (nout >= NF * N) begin
         for (int f = 0; f < NF; f++) begin
            check_frame(f);
            // R3 latency (R5 for the back-to-back frames)
            check(tfirst[f] == tcap[f] + LAT, (f >= 4) ? "R5" : "R3",
                  $sformatf("frame %0d latency", f),
                  $sformatf("%0d", tfirst[f] - tcap[f]), $sformatf("%0d", LAT));
            // R4: the frame's outputs are consecutive
            check(tlast[f] - tfirst[f] == N - 1, "R4",
                  $sformatf("frame %0d output span", f),
                  $sformatf("%0d", tlast[f] - tfirst[f]), $sformatf("%0d", N - 1));
         end
      end else begin
         check(1'b0, "R4", "frames collected before timeout",
               $sformatf("%0d", nout), $sformatf("%0d", NF * N));
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(8 * 200000);
      errors++;
      checks++;
      $display("FAIL R4 watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule